// File: doc/BRIEF.md
# DTMF Tone Burst Generator

This block produces the two square-wave signalling tones for one telephone keypad symbol. It divides a 3.579545 MHz reference clock with one counter per tone channel. The low-group channel takes its half-period divisor from the row field of the key code, and the high-group channel takes its divisor from the column field. The divisors are integer approximations, so every tone carries a small, fixed frequency error. Each divisor is computed at elaboration time from the reference frequency parameter.

A keypad controller gives a key code together with a one-cycle request while `ready` is high. The block then runs a timed burst. The burst lasts at least a set number of millisecond ticks and continues for as long as the key stays held. A silent gap of a set minimum length follows the burst. `ready` stays low through both phases, and any request made during that time is dropped. When tone signalling is switched off (for example, while the line is in pulse dialing), the block ignores requests and keeps both tone outputs low. Summing the tones, pre-emphasis and D/A shaping are done by later stages.

Top module: `dtmf_burst_gen`

## Requirements
- R1: Row field `key_code[3:2]` = 0, 1, 2, 3 selects a `row_wave` frequency within 0.75% of 697, 770, 852 and 941 Hz respectively. The frequency is derived from the reference clock, whose half-period is counted in whole clock cycles.
- R2: Column field `key_code[1:0]` = 0, 1, 2 selects a `col_wave` frequency within 0.75% of 1209, 1336 and 1477 Hz respectively.
- R3: A burst (`tone_active` high) lasts until at least 93 `ms_tick` pulses have been counted. It continues for as long as `key_held` stays high, and ends on the clock edge after `key_held` is seen low once the minimum has been met.
- R4: After each burst, `ready` stays low for a silent gap of at least 93 `ms_tick` pulses. Both tone outputs are low during the gap. `ready` then returns high.
- R5: While `tone_en` is low, a request is ignored: `ready` stays high, `tone_active` stays low, and both tone outputs are low. Both outputs are also forced low no later than one edge after `tone_en` falls in the middle of a burst.
- R6: Column field value 3 marks a multi-key report. In that case only the row tone is produced and `col_wave` stays low for the whole burst.
- R7: A request made while `ready` is low is dropped. It neither changes the current burst nor starts a later one.
- R8: While reset is asserted and right after it, `row_wave`, `col_wave` and `tone_active` are low and `ready` is high.
- R9: An accepted request raises `tone_active` and lowers `ready` at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (3.579545 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | 1 | Tone signalling enabled; low means tones are muted and requests are refused |
| key_code | input | 4 | Row field in [3:2], column field in [1:0] (column value 3 means single tone) |
| key_req | input | 1 | One-cycle request strobe, accepted only while `ready` is high |
| key_held | input | 1 | Key still pressed; extends the burst beyond its minimum |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| row_wave | output | 1 | Low-group square wave |
| col_wave | output | 1 | High-group square wave |
| tone_active | output | 1 | Burst in progress |
| ready | output | 1 | Idle and able to accept a request |

## Verification
`tone_active` and `ready` change on the first rising edge after a request is accepted. The bench checks them at the falling edge that follows, one cycle after it drives the strobe. Each wave first toggles one half-period after the burst starts. The half-period is taken as the number of falling-edge samples between the first and second toggles, which removes any start-up offset before the frequency is compared with the tolerance. Burst and gap lengths depend on where the free-running millisecond tick falls relative to the request. They are therefore checked against a window one tick period wide, while a held key is checked against its release time to within two cycles.

// File: rtl/dtmf_tone_pkg.sv
package dtmf_tone_pkg;

   localparam int unsigned TONE_SLOTS = 8;

   typedef enum logic [1:0] {
      TM_IDLE  = 2'd0,
      TM_BURST = 2'd1,
      TM_GAP   = 2'd2
   } tmr_state_t;

   // slot 0..3: low group, slot 4..6: high group, slot 7: spare
   function automatic int unsigned tone_hz(input int unsigned slot);
      case (slot)
         0:       return 697;
         1:       return 770;
         2:       return 852;
         3:       return 941;
         4:       return 1209;
         5:       return 1336;
         default: return 1477;
      endcase
   endfunction

   // rounded half-period in reference cycles
   function automatic int unsigned half_period(input int unsigned ref_hz,
                                               input int unsigned slot);
      return (ref_hz + tone_hz(slot)) / (2 * tone_hz(slot));
   endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half_div,
   output logic             wave
);

   logic [DIV_W-1:0] cnt;

   initial begin : p_elab
      assert (DIV_W >= 2) else $error("tone_divider: DIV_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         wave <= 1'b0;
      end else if (cnt >= half_div - 1'b1) begin
         cnt  <= '0;
         wave <= ~wave;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> cnt < half_div) else $error("AST_CNT_BOUND"); // R1

endmodule

// File: rtl/burst_timer.sv
module burst_timer
   import dtmf_tone_pkg::*;
#(
   parameter int MIN_BURST = 93,
   parameter int MIN_GAP   = 93
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic key_held,
   input  logic ms_tick,
   output logic in_burst,
   output logic ready
);

   localparam int MAX_TICKS = (MIN_BURST > MIN_GAP) ? MIN_BURST : MIN_GAP;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);
   localparam logic [CNT_W-1:0] BURST_END = CNT_W'(MIN_BURST);
   localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(MIN_GAP);

   tmr_state_t       state;
   logic [CNT_W-1:0] ticks;

   initial begin : p_elab
      assert (MIN_BURST > 0 && MIN_GAP > 0)
         else $error("burst_timer: minimum lengths must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TM_IDLE;
         ticks <= '0;
      end else begin
         case (state)
            TM_IDLE: begin
               ticks <= '0;
               if (start) state <= TM_BURST;
            end
            TM_BURST: begin
               if (ticks == BURST_END && !key_held) begin
                  state <= TM_GAP;
                  ticks <= '0;
               end else if (ms_tick && ticks != BURST_END) begin
                  ticks <= ticks + 1'b1;
               end
            end
            TM_GAP: begin
               if (ticks == GAP_END) begin
                  state <= TM_IDLE;
                  ticks <= '0;
               end else if (ms_tick) begin
                  ticks <= ticks + 1'b1;
               end
            end
            default: begin
               state <= TM_IDLE;
               ticks <= '0;
            end
         endcase
      end
   end

   assign in_burst = (state == TM_BURST);
   assign ready    = (state == TM_IDLE);

   AST_MIN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_burst) |-> $past(ticks == BURST_END)) else $error("AST_MIN_BURST"); // R3
   AST_HELD_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst && key_held |=> in_burst) else $error("AST_HELD_EXTENDS"); // R3
   AST_GAP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(state == TM_GAP && ticks == GAP_END)) else $error("AST_GAP_DONE"); // R4

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
   import dtmf_tone_pkg::*;
#(
   parameter int unsigned REF_HZ       = 3579545,
   parameter int          MIN_BURST_MS = 93,
   parameter int          MIN_GAP_MS   = 93
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tone_en,
   input  logic [3:0] key_code,
   input  logic       key_req,
   input  logic       key_held,
   input  logic       ms_tick,
   output logic       row_wave,
   output logic       col_wave,
   output logic       tone_active,
   output logic       ready
);

   localparam int unsigned MAX_HALF = half_period(REF_HZ, 0);
   localparam int          DIV_W    = $clog2(MAX_HALF + 1);
   localparam int          SLOT_W   = $clog2(TONE_SLOTS);

   initial begin : p_elab
      assert (REF_HZ > 4 * tone_hz(6))
         else $error("dtmf_burst_gen: reference clock too slow");
   end

   logic [3:0]        code_q;
   logic              accept;
   logic              burst_en;
   logic              col_present;
   logic [SLOT_W-1:0] row_slot;
   logic [SLOT_W-1:0] col_slot;
   logic [DIV_W-1:0]  div_tab [TONE_SLOTS];
   logic [1:0]        waves;

   for (genvar s = 0; s < TONE_SLOTS; s++) begin : g_tab
      assign div_tab[s] = DIV_W'(half_period(REF_HZ, s));
   end

   assign accept = key_req && ready && tone_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (accept) code_q <= key_code;
   end

   burst_timer #(
      .MIN_BURST (MIN_BURST_MS),
      .MIN_GAP   (MIN_GAP_MS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .key_held (key_held),
      .ms_tick  (ms_tick),
      .in_burst (tone_active),
      .ready    (ready)
   );

   assign burst_en    = tone_active && tone_en;
   assign col_present = (code_q[1:0] != 2'd3);
   assign row_slot    = {1'b0, code_q[3:2]};
   assign col_slot    = 3'd4 + {1'b0, code_q[1:0]};

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      logic             ch_en;
      logic [DIV_W-1:0] ch_div;
      if (ch == 0) begin : g_low
         assign ch_en  = burst_en;
         assign ch_div = div_tab[row_slot];
      end else begin : g_high
         assign ch_en  = burst_en && col_present;
         assign ch_div = div_tab[col_slot];
      end
      tone_divider #(.DIV_W(DIV_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (ch_en),
         .half_div (ch_div),
         .wave     (waves[ch])
      );
   end

   assign row_wave = waves[0];
   assign col_wave = waves[1];

   AST_MUTE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_en |=> !row_wave && !col_wave) else $error("AST_MUTE_OUT"); // R5
   AST_MUTE_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_en && ready |=> ready) else $error("AST_MUTE_REFUSE"); // R5
   AST_SINGLE_TONE: assert property (@(posedge clk) disable iff (!rst_n)
      tone_active && code_q[1:0] == 2'd3 |-> !col_wave) else $error("AST_SINGLE_TONE"); // R6
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      key_req && !ready |=> $stable(code_q)) else $error("AST_HOLD_OFF"); // R7
   AST_START: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> tone_active && !ready) else $error("AST_START"); // R9

endmodule

// File: tb/dtmf_burst_gen_test.sv
`timescale 1ns/1ps
module dtmf_burst_gen_test;

   localparam int TICK_P = 64;
   localparam int MIN_T  = 93;
   localparam int LEN_LO = (MIN_T - 1) * TICK_P;
   localparam int LEN_HI = MIN_T * TICK_P + 2;
   localparam int HOLD   = 150 * TICK_P;

   typedef struct {
      int row;
      int col;
      int min_len;
      int max_len;
      bit chk_freq;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tone_en;
   logic [3:0] key_code;
   logic       key_req;
   logic       key_held;
   logic       ms_tick;
   logic       row_wave, col_wave, tone_active, ready;

   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   exp_t sbq[$];
   int   rowf[4] = '{697, 770, 852, 941};
   int   colf[3] = '{1209, 1336, 1477};

   always #2 clk = ~clk;

   dtmf_burst_gen uut (
      .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .key_code(key_code),
      .key_req(key_req), .key_held(key_held), .ms_tick(ms_tick),
      .row_wave(row_wave), .col_wave(col_wave),
      .tone_active(tone_active), .ready(ready)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_freq(input string req, input int half, input int nom);
      real f;
      real err;
      f   = (half > 0) ? 3579545.0 / (2.0 * half) : 0.0;
      err = (f > nom) ? (f - nom) / nom : (nom - f) / nom;
      chk(half > 0 && err <= 0.0075, req, "tone frequency Hz", int'(f), nom);
   endtask

   always @(negedge clk) begin
      cyc++;
      ms_tick = ((cyc % TICK_P) == 0);
      if (cyc > 190000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   // driver: push expectation, issue request, check start timing
   task automatic send(input logic [3:0] code, input int hold, input bit freq);
      exp_t e;
      while (!ready) @(negedge clk);
      e.row = code[3:2];
      e.col = code[1:0];
      e.min_len  = (hold > 0) ? hold - 1 : LEN_LO;
      e.max_len  = (hold > 0) ? hold + 2 : LEN_HI;
      e.chk_freq = freq;
      sbq.push_back(e);
      key_code = code;
      key_req  = 1'b1;
      key_held = (hold > 0);
      @(negedge clk);
      key_req = 1'b0;
      chk(tone_active && !ready, "R9", "burst start", {tone_active, ready}, 2);
      if (hold > 0) begin
         repeat (hold - 1) @(negedge clk);
         key_held = 1'b0;
      end
   endtask

   task automatic finish_wait();
      while (sbq.size() != 0) @(negedge clk);
   endtask

   // monitor: measure each burst and gap, compare with the queue head
   initial begin
      forever begin
         int   len, gap, rt, ct, r0, r1, c0, c1;
         logic pr, pc;
         exp_t e;
         @(negedge clk);
         if (tone_active !== 1'b1) continue;
         len = 0; rt = 0; ct = 0; r0 = 0; r1 = 0; c0 = 0; c1 = 0;
         pr = row_wave; pc = col_wave;
         while (tone_active) begin
            len++;
            if (row_wave != pr) begin rt++; if (rt == 1) r0 = len; if (rt == 2) r1 = len; end
            if (col_wave != pc) begin ct++; if (ct == 1) c0 = len; if (ct == 2) c1 = len; end
            pr = row_wave; pc = col_wave;
            @(negedge clk);
         end
         gap = 0;
         while (!ready) begin
            if (row_wave || col_wave) ct = ct + 100;
            gap++;
            @(negedge clk);
         end
         if (sbq.size() == 0) begin
            chk(1'b0, "R7", "unexpected burst length", len, 0);
         end else begin
            e = sbq.pop_front();
            chk(len >= e.min_len && len <= e.max_len, "R3", "burst cycles", len, e.min_len);
            chk(gap >= LEN_LO && gap <= LEN_HI, "R4", "gap cycles", gap, LEN_LO);
            if (e.chk_freq) begin
               chk_freq("R1", r1 - r0, rowf[e.row]);
               if (e.col == 3) chk(ct == 0, "R6", "column toggles", ct, 0);
               else            chk_freq("R2", c1 - c0, colf[e.col]);
            end
         end
      end
   end

   initial begin
      rst_n = 1'b0; tone_en = 1'b1; key_code = '0;
      key_req = 1'b0; key_held = 1'b0; ms_tick = 1'b0;
      repeat (3) @(negedge clk);
      chk(!row_wave && !col_wave && !tone_active && ready, "R8", "reset outputs",
          {row_wave, col_wave, tone_active, ready}, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!row_wave && !col_wave && !tone_active && ready, "R8", "after reset",
          {row_wave, col_wave, tone_active, ready}, 1);

      send(4'b0000, 0, 1'b1); finish_wait();
      send(4'b0101, 0, 1'b1); finish_wait();
      send(4'b1010, 0, 1'b1); finish_wait();
      send(4'b1100, 0, 1'b1); finish_wait();
      send(4'b0111, 0, 1'b1); finish_wait();   // R6 single tone
      send(4'b0010, HOLD, 1'b1); finish_wait(); // R3 held key

      // R7: request during a burst is dropped
      send(4'b1001, 0, 1'b1);
      repeat (200) @(negedge clk);
      key_code = 4'b0000; key_req = 1'b1;
      @(negedge clk);
      key_req = 1'b0;
      chk(tone_active && !ready, "R7", "still busy", {tone_active, ready}, 2);
      finish_wait();
      repeat (300) @(negedge clk);
      chk(!tone_active && ready, "R7", "no extra burst", {tone_active, ready}, 1);

      // R5: muted requests are refused
      tone_en = 1'b0;
      key_code = 4'b0101; key_req = 1'b1;
      @(negedge clk);
      key_req = 1'b0;
      repeat (50) @(negedge clk);
      chk(!tone_active && ready && !row_wave && !col_wave, "R5", "muted request",
          {tone_active, ready, row_wave, col_wave}, 4);
      tone_en = 1'b1;

      // R5: mute in the middle of a burst
      send(4'b0000, 0, 1'b0);
      repeat (3000) @(negedge clk);
      tone_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!row_wave && !col_wave, "R5", "muted mid-burst", {row_wave, col_wave}, 0);
      tone_en = 1'b1;
      finish_wait();

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule